// File: doc/BRIEF.md
# Address Translation Unit with Page-Table Walker

This block turns a 32-bit virtual address into a physical address. Pages are 4 KB. The low 12 bits of the address are the byte offset, and the upper 20 bits are the virtual page number (VPN). The block keeps eight recent VPN-to-frame mappings in a small associative array and compares every stored tag against the incoming VPN in parallel. When a tag matches, the frame number replaces the VPN and the offset passes through unchanged. No memory access is made.

When no tag matches, the block fetches the page-table entry (PTE) itself from a flat, single-level table. The table sits in memory at the address held on `pt_base`. The block installs the mapping into the array and then answers. If the PTE is marked invalid, the answer carries a fault flag and nothing is installed. The block takes requests through a valid/ready handshake and holds at most one request at a time. It returns results through a valid/ready response channel. A flush input empties the array.

Top module: `vtrans_unit`

## Requirements
- R1: The response address is the frame number placed in bits [31:12] with the request's offset bits [11:0] unchanged. For example, virtual 0x00003F7C, when page 3 maps to frame 0x00A, gives 0x0000AF7C.
- R2: When a valid stored entry matches the VPN, `rsp_valid` rises in the cycle after the request is accepted, and no memory read is issued.
- R3: On a miss, exactly one memory read is issued, at address `pt_base + VPN*4`. The response follows the return of the read data, and a later request to the same page hits.
- R4: The 32-bit PTE word uses bit 0 as the valid flag and bits [31:12] as the frame number. If bit 0 is 0, the response has `rsp_fault`=1 and `rsp_paddr`=0, and no mapping is installed, so a repeat request to that page misses again.
- R5: After reset all entries are empty, so the first request to any page misses. After reset `req_ready`=1, `rsp_valid`=0 and `mem_rd_req`=0.
- R6: A refill writes the lowest-indexed empty entry. When all eight entries are valid, it writes the entry chosen by a replacement pointer. The pointer starts at 0 after reset and advances by one, wrapping, after each such replacement.
- R7: `req_ready` is low from the cycle after a request is accepted until its response is accepted. While `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold steady.
- R8: When `flush` is high for one cycle, every entry is emptied, and the next request to any page misses.
- R9: A request accepted in the same cycle as `flush` is handled as a miss. A refill whose PTE data arrives in a cycle where `flush` is high installs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty every entry |
| pt_base | input | 32 | Byte address of page-table entry 0 |
| req_valid | input | 1 | Translate request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | PTE was invalid |
| mem_rd_req | output | 1 | One-cycle read strobe for a PTE |
| mem_rd_addr | output | 32 | PTE byte address |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | 32 | PTE word |

## Verification
The bench builds the block with its default parameters: 4 KB pages, 32-bit addresses and eight entries. With eight entries, nine distinct pages are enough to fill the array and force replacements, so the pointer wrap, the ordering of victims and the survival of the other entries can all be observed through hits and misses. The bench's memory model answers three cycles after each read strobe. That gives a fixed window in which a flush can be made to coincide with the returning PTE data.

// File: rtl/vtrans_pkg.sv
package vtrans_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } vt_state_e;
endpackage

// File: rtl/vtrans_victim.sv
// Refill slot choice: lowest empty slot, else the replacement pointer.
module vtrans_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] slot_valid,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   pick_idx,
    output logic               pick_full
);
    always_comb begin
        pick_full = &slot_valid;
        pick_idx  = rr_ptr;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!slot_valid[i]) pick_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/vtrans_cam.sv
// Associative mapping store: parallel tag compare, refill, flush.
module vtrans_cam #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PFN_W-1:0] ins_pfn
);
    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][VPN_W-1:0] tag;
        logic [ENTRIES-1:0][PFN_W-1:0] pfn;
        logic [IDX_W-1:0]              rr;
    } cam_t;

    cam_t cam_d, cam_q;
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   vic_idx;
    logic               vic_full;
    logic [IDX_W-1:0]   rr_next;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = cam_q.valid[g] && (cam_q.tag[g] == lk_vpn);
        end
    endgenerate

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_pfn = lk_pfn | cam_q.pfn[i];
        end
    end
    assign lk_hit = |match;

    vtrans_victim #(.ENTRIES(ENTRIES)) u_victim (
        .slot_valid (cam_q.valid),
        .rr_ptr     (cam_q.rr),
        .pick_idx   (vic_idx),
        .pick_full  (vic_full)
    );

    assign rr_next = (cam_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : cam_q.rr + 1'b1;

    always_comb begin
        cam_d = cam_q;
        if (flush) begin
            cam_d.valid = '0;
        end else if (ins_en) begin
            cam_d.valid[vic_idx] = 1'b1;
            cam_d.tag[vic_idx]   = ins_vpn;
            cam_d.pfn[vic_idx]   = ins_pfn;
            if (vic_full) cam_d.rr = rr_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cam_q <= '0;
        else        cam_q <= cam_d;
    end
endmodule

// File: rtl/vtrans_unit.sv
// Translate request sequencer with built-in single-level table walk.
module vtrans_unit
    import vtrans_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ENTRIES   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [PA_W-1:0] pt_base,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            rsp_fault,
    output logic            mem_rd_req,
    output logic [PA_W-1:0] mem_rd_addr,
    input  logic            mem_rd_valid,
    input  logic [PA_W-1:0] mem_rd_data
);
    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PFN_W = PA_W - PAGE_BITS;

    typedef struct packed {
        vt_state_e       st;
        logic [VA_W-1:0] vaddr;
        logic [PA_W-1:0] paddr;
        logic            fault;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic             lk_hit;
    logic [PFN_W-1:0] lk_pfn;
    logic             ins_en;
    logic [VPN_W-1:0] cur_vpn;
    logic [PFN_W-1:0] pte_pfn;
    logic             pte_ok;
    logic             unused_pte_bits;

    assign cur_vpn         = ctl_q.vaddr[VA_W-1:PAGE_BITS];
    assign pte_pfn         = mem_rd_data[PA_W-1:PAGE_BITS];
    assign pte_ok          = mem_rd_data[0];
    assign unused_pte_bits = ^mem_rd_data[PAGE_BITS-1:1];

    vtrans_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_cam (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .lk_vpn  (req_vaddr[VA_W-1:PAGE_BITS]),
        .lk_hit  (lk_hit),
        .lk_pfn  (lk_pfn),
        .ins_en  (ins_en),
        .ins_vpn (cur_vpn),
        .ins_pfn (pte_pfn)
    );

    assign req_ready   = (ctl_q.st == ST_IDLE);
    assign rsp_valid   = (ctl_q.st == ST_RESP);
    assign rsp_paddr   = ctl_q.paddr;
    assign rsp_fault   = ctl_q.fault;
    assign mem_rd_req  = (ctl_q.st == ST_FETCH);
    assign mem_rd_addr = pt_base + PA_W'({cur_vpn, 2'b00});

    always_comb begin
        ctl_d  = ctl_q;
        ins_en = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.vaddr = req_vaddr;
                    if (lk_hit && !flush) begin
                        ctl_d.paddr = {lk_pfn, req_vaddr[PAGE_BITS-1:0]};
                        ctl_d.fault = 1'b0;
                        ctl_d.st    = ST_RESP;
                    end else begin
                        ctl_d.st = ST_FETCH;
                    end
                end
            end
            ST_FETCH: ctl_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rd_valid) begin
                    if (pte_ok) begin
                        ins_en      = 1'b1;
                        ctl_d.paddr = {pte_pfn, ctl_q.vaddr[PAGE_BITS-1:0]};
                        ctl_d.fault = 1'b0;
                    end else begin
                        ctl_d.paddr = '0;
                        ctl_d.fault = 1'b1;
                    end
                    ctl_d.st = ST_RESP;
                end
            end
            ST_RESP: begin
                if (rsp_ready) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.vaddr <= '0;
            ctl_q.paddr <= '0;
            ctl_q.fault <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/vtrans_unit_chk.sv
module vtrans_unit_chk #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_fault,
    input logic            mem_rd_req
);
    logic [VA_W-1:0] acc_q;
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else if (req_valid && req_ready) acc_q <= req_vaddr;
    end

    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[PAGE_BITS-1:0] == acc_q[PAGE_BITS-1:0]));

    assert_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    assert_fault_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_no_ready_with_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (rsp_valid || mem_rd_req)));

    assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));
endmodule

bind vtrans_unit vtrans_unit_chk #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_paddr  (rsp_paddr),
    .rsp_fault  (rsp_fault),
    .mem_rd_req (mem_rd_req)
);

// File: tb/vtrans_unit_bench.sv
module vtrans_unit_bench;
    localparam logic [31:0] BASE = 32'h0040_0000;
    localparam int NVEC = 9;
    // {vaddr, expect_miss, expect_fault}
    localparam logic [33:0] VEC [NVEC] = '{
        {32'h0000_3F7C, 1'b1, 1'b0},
        {32'h0000_3000, 1'b0, 1'b0},
        {32'h0000_1234, 1'b1, 1'b0},
        {32'h0000_1FFF, 1'b0, 1'b0},
        {32'hF000_2010, 1'b1, 1'b1},
        {32'hF000_2FFC, 1'b1, 1'b1},
        {32'h0000_3ABC, 1'b0, 1'b0},
        {32'h7FFF_F001, 1'b1, 1'b0},
        {32'h7FFF_F800, 1'b0, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic req_valid = 1'b0, rsp_ready = 1'b1;
    logic [31:0] req_vaddr = '0;
    logic req_ready, rsp_valid, rsp_fault, mem_rd_req;
    logic [31:0] rsp_paddr, mem_rd_addr;
    logic mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;

    int total = 0, bad = 0, reads = 0, pend = 0;
    logic [31:0] pend_addr = '0, last_addr = '0;
    bit done = 0;

    always #10 clk = ~clk;

    vtrans_unit u_vtrans_unit (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(BASE),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    function automatic logic [31:0] pte_of(input logic [31:0] a);
        logic [19:0] v;
        v = 20'((a - BASE) >> 2);
        return {v + 20'd7, 11'd0, (v[19:16] != 4'hF)};
    endfunction

    function automatic logic [31:0] exp_pa(input logic [31:0] va, input bit flt);
        return flt ? 32'd0 : {va[31:12] + 20'd7, va[11:0]};
    endfunction

    // page-table memory: answers three cycles after a strobe
    always @(posedge clk) begin
        mem_rd_valid <= 1'b0;
        if (pend > 0) begin
            pend <= pend - 1;
            if (pend == 1) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= pte_of(pend_addr);
            end
        end
        if (mem_rd_req) begin
            pend      <= 3;
            pend_addr <= mem_rd_addr;
            last_addr <= mem_rd_addr;
            reads     <= reads + 1;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    // mode: 0 plain, 1 hold response two cycles, 2 flush at accept, 3 flush at PTE return
    task automatic xlate(input logic [31:0] va, input bit miss, input bit flt,
                         input string rq, input int mode);
        int r0, cyc;
        logic [31:0] held;
        @(negedge clk);
        r0 = reads;
        chk(req_ready, "R7", "idle ready", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_vaddr = va;
        if (mode == 1) rsp_ready = 1'b0;
        if (mode == 2) flush = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; flush = 1'b0;
        cyc = 1;
        while (!rsp_valid && cyc < 40) begin
            if (!req_ready == 1'b0) chk(1'b0, "R7", "ready during walk", 32'(req_ready), 32'd0);
            if (mode == 3 && mem_rd_valid) flush = 1'b1;
            @(negedge clk);
            flush = 1'b0;
            cyc++;
        end
        chk(rsp_valid, rq, "response arrives", 32'(cyc), 32'd40);
        chk((reads - r0) == (miss ? 1 : 0), rq, "memory reads", 32'(reads - r0), miss ? 32'd1 : 32'd0);
        if (!miss) chk(cyc == 1, "R2", "hit latency", 32'(cyc), 32'd1);
        if (miss) chk(last_addr == BASE + {10'd0, va[31:12], 2'b00}, "R3", "PTE address",
                      last_addr, BASE + {10'd0, va[31:12], 2'b00});
        chk(rsp_paddr == exp_pa(va, flt), rq, "paddr", rsp_paddr, exp_pa(va, flt));
        chk(rsp_fault == flt, rq, "fault", 32'(rsp_fault), 32'(flt));
        if (mode == 1) begin
            held = rsp_paddr;
            repeat (2) @(negedge clk);
            chk(rsp_valid && !req_ready && rsp_paddr == held, "R7", "held response",
                rsp_paddr, held);
            rsp_ready = 1'b1;
        end
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R7", "released", {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_rd_req, "R5", "reset outputs",
            {29'd0, req_ready, rsp_valid, mem_rd_req}, 32'd4);

        // table walk: R1 R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++)
            xlate(VEC[i][33:2], VEC[i][1], VEC[i][0], "R1", 0);

        // R7 backpressure on a hit
        xlate(32'h0000_3123, 1'b0, 1'b0, "R7", 1);

        // R6 fill and replacement order
        rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1;
        for (int p = 0; p < 8; p++) xlate({20'h00100 + 20'(p), 12'h010}, 1'b1, 1'b0, "R6", 0);
        for (int p = 0; p < 8; p++) xlate({20'h00100 + 20'(p), 12'h020}, 1'b0, 1'b0, "R6", 0);
        xlate(32'h0010_8004, 1'b1, 1'b0, "R6", 0);   // evicts slot 0 (page 0x100)
        for (int p = 1; p < 8; p++) xlate({20'h00100 + 20'(p), 12'h030}, 1'b0, 1'b0, "R6", 0);
        xlate(32'h0010_0040, 1'b1, 1'b0, "R6", 0);   // evicts slot 1 (page 0x101)
        xlate(32'h0010_1050, 1'b1, 1'b0, "R6", 0);   // evicts slot 2 (page 0x102)
        xlate(32'h0010_8060, 1'b0, 1'b0, "R6", 0);
        xlate(32'h0010_3070, 1'b0, 1'b0, "R6", 0);

        // R8 flush empties the array
        @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
        xlate(32'h0010_8080, 1'b1, 1'b0, "R8", 0);
        xlate(32'h0010_3090, 1'b1, 1'b0, "R8", 0);

        // R9 flush at accept and flush at refill
        xlate(32'h0000_5000, 1'b1, 1'b0, "R9", 0);
        xlate(32'h0000_5004, 1'b0, 1'b0, "R9", 0);
        xlate(32'h0000_5008, 1'b1, 1'b0, "R9", 2);
        xlate(32'h0000_600C, 1'b1, 1'b0, "R9", 3);
        xlate(32'h0000_6010, 1'b1, 1'b0, "R9", 0);
        xlate(32'h0000_6014, 1'b0, 1'b0, "R9", 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule